// File: doc/BRIEF.md
# Descriptor-Driven Raster Timing Generator

This block turns one packed 20-byte detailed timing descriptor into a running video raster. The descriptor arrives one byte per clock over a simple load port, with a start-of-descriptor marker on its first byte. Once all twenty bytes are in, the block decodes them and checks that they make sense. A good descriptor is held until the current frame ends and then becomes the live timing. A bad descriptor is flagged and thrown away, and the previous timing keeps running.

The live timing drives two pixel-rate counters, horizontal and vertical. From them the block derives a data-enable, active-area coordinates, and horizontal and vertical sync. Each sync has its own polarity, taken from the descriptor. The blanking on each axis is given as a total. Inside it the front porch comes first, then the sync pulse, then the rest of the blank. The block does not make a pixel clock: the pixel-rate field and the timing option bits only appear as outputs. A descriptor marked interlaced is accepted and flagged, but the raster it produces is progressive.

The sync, data-enable, position and coordinate outputs all come from one register stage, so they line up with each other.

Top module: `vtg_desc_top`

## Requirements
- R1: A byte with `ld_valid` and `ld_sof` high is stored as byte 0 and restarts collection. Each later valid byte is stored at the next index. A descriptor is complete on byte 19. Valid bytes after byte 19 and before the next start marker are ignored. An incomplete load raises neither status flag.
- R2: The byte layout is little-endian throughout:
  - Bytes 0 to 2 are the pixel rate. Byte 3 holds aspect in bits 3:0, interlaced in bit 4, stereo in bits 6:5 and preferred in bit 7.
  - Horizontal fields: bytes 4-5 are active pixels, 6-7 total blank, 8-9 front porch in bits 14:0 with polarity in bit 15, 10-11 sync width.
  - Bytes 12 to 19 hold the same four fields for the vertical axis, in lines.
  - `pix_rate_khz`, `aspect_code`, `interlaced`, `stereo_mode` and `preferred` show these values for the descriptor in effect.
- R3: `h_pos` counts 0 up to active+blank-1 on the horizontal axis, one step per clock, then returns to 0.
- R4: `v_pos` advances by one only when `h_pos` wraps, and returns to 0 after active+blank-1 lines.
- R5: `de` is high exactly when `h_pos` is below horizontal active and `v_pos` is below vertical active. `act_x` and `act_y` equal `h_pos` and `v_pos` while `de` is high, and are 0 otherwise.
- R6: Horizontal sync is asserted for `h_pos` in [active+porch, active+porch+width). Vertical sync uses the same rule on `v_pos`. An asserted sync is 1 when its polarity bit is 1 and 0 when it is 0. A deasserted sync is the inverse. A width of 0 gives no pulse.
- R7: An accepted descriptor takes effect only at a frame boundary. After the last position of the old frame, the next position is (0,0) under the new totals. The first accepted descriptor after reset starts at (0,0) straight away.
- R8: A descriptor is rejected when either active field is 0, or when porch+width exceeds blank on either axis. On rejection `desc_bad` goes high, `desc_ok` stays low, and the running timing is unchanged. On acceptance `desc_ok` goes high. Both flags clear on the next start marker. Porch+width equal to blank is accepted.
- R9: After reset, all outputs are 0 and `timing_run` is 0. The counters stay at 0 until a descriptor is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Load byte valid |
| ld_sof | input | 1 | Marks byte 0 of a descriptor |
| ld_data | input | 8 | Load byte |
| desc_ok | output | 1 | Last complete descriptor accepted |
| desc_bad | output | 1 | Last complete descriptor rejected |
| timing_run | output | 1 | Raster running |
| h_pos | output | 17 | Horizontal position |
| v_pos | output | 17 | Vertical position |
| act_x | output | 16 | Active-area column |
| act_y | output | 16 | Active-area row |
| de | output | 1 | Data enable |
| hsync | output | 1 | Horizontal sync, descriptor polarity |
| vsync | output | 1 | Vertical sync, descriptor polarity |
| pix_rate_khz | output | 24 | Pixel rate field of the live timing |
| aspect_code | output | 4 | Aspect field of the live timing |
| interlaced | output | 1 | Interlace flag of the live timing |
| stereo_mode | output | 2 | Stereo field of the live timing |
| preferred | output | 1 | Preferred flag of the live timing |

## Verification
The hardest situation to reach is a handoff at the frame boundary. A new descriptor must be fully loaded and accepted while an old raster is in mid-frame, and the swap has to be seen on the exact cycle after the old frame's last position. The stimulus reaches this by waiting until the outputs show the start of line 1, then streaming the descriptor, which leaves a whole frame of margin before the boundary. A monitor follows every output position against the successor it predicts, and it switches its own copy of the timing on the sample that shows (0,0). Rejected descriptors, a truncated load followed by a restart, and trailing extra bytes are pushed through the same path, so that a timing which should not have changed would show up as a wrong successor.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

  localparam int DESC_BYTES = 20;
  localparam int AXW        = 16;
  localparam int FPW        = AXW - 1;
  localparam int RATEW      = 24;
  localparam int OFS_H      = 4;
  localparam int OFS_V      = 12;
  localparam int XW         = AXW + 2;

  typedef struct packed {
    logic [AXW-1:0] act;
    logic [AXW-1:0] blank;
    logic [FPW-1:0] fp;
    logic           pol;
    logic [AXW-1:0] sw;
  } axis_cfg_t;

  typedef struct packed {
    logic [RATEW-1:0] rate;
    logic [3:0]       aspect;
    logic             ilace;
    logic [1:0]       stereo;
    logic             pref;
    axis_cfg_t        h;
    axis_cfg_t        v;
  } tim_cfg_t;

  function automatic axis_cfg_t unpack_axis(input logic [7:0] b0, input logic [7:0] b1,
                                            input logic [7:0] b2, input logic [7:0] b3,
                                            input logic [7:0] b4, input logic [7:0] b5,
                                            input logic [7:0] b6, input logic [7:0] b7);
    axis_cfg_t r;
    r.act   = {b1, b0};
    r.blank = {b3, b2};
    r.fp    = {b5[6:0], b4};
    r.pol   = b5[7];
    r.sw    = {b7, b6};
    return r;
  endfunction

  function automatic logic axis_ok(input axis_cfg_t a);
    logic [XW-1:0] need;
    need = XW'(a.fp) + XW'(a.sw);
    return (a.act != '0) && (need <= XW'(a.blank));
  endfunction

endpackage

// File: rtl/vtg_desc_loader.sv
module vtg_desc_loader
  import vtg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ld_valid,
  input  logic       ld_sof,
  input  logic [7:0] ld_data,
  output tim_cfg_t   cfg_o,
  output logic       cfg_new_o,
  output logic       ok_o,
  output logic       bad_o
);

  localparam int IW = $clog2(DESC_BYTES + 1);

  logic [7:0]    mem [DESC_BYTES];
  logic [IW-1:0] idx;
  logic [IW-1:0] wr_idx;
  logic          wr_en;
  logic          done_q;
  tim_cfg_t      dec;
  logic          dec_ok;

  assign wr_idx = ld_sof ? '0 : idx;
  assign wr_en  = ld_valid && (ld_sof || (idx < IW'(DESC_BYTES)));

  // byte store, no reset so it maps to plain storage
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= ld_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx    <= IW'(DESC_BYTES);
      done_q <= 1'b0;
    end else begin
      done_q <= wr_en && (wr_idx == IW'(DESC_BYTES - 1));
      if (wr_en) idx <= wr_idx + 1'b1;
    end
  end

  always_comb begin
    dec.rate   = {mem[2], mem[1], mem[0]};
    dec.aspect = mem[3][3:0];
    dec.ilace  = mem[3][4];
    dec.stereo = mem[3][6:5];
    dec.pref   = mem[3][7];
    dec.h = unpack_axis(mem[OFS_H+0], mem[OFS_H+1], mem[OFS_H+2], mem[OFS_H+3],
                        mem[OFS_H+4], mem[OFS_H+5], mem[OFS_H+6], mem[OFS_H+7]);
    dec.v = unpack_axis(mem[OFS_V+0], mem[OFS_V+1], mem[OFS_V+2], mem[OFS_V+3],
                        mem[OFS_V+4], mem[OFS_V+5], mem[OFS_V+6], mem[OFS_V+7]);
    dec_ok = axis_ok(dec.h) && axis_ok(dec.v);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_o     <= '0;
      cfg_new_o <= 1'b0;
      ok_o      <= 1'b0;
      bad_o     <= 1'b0;
    end else begin
      cfg_new_o <= 1'b0;
      if (ld_valid && ld_sof) begin
        ok_o  <= 1'b0;
        bad_o <= 1'b0;
      end
      if (done_q) begin
        ok_o  <= dec_ok;
        bad_o <= !dec_ok;
        if (dec_ok) begin
          cfg_o     <= dec;
          cfg_new_o <= 1'b1;
        end
      end
    end
  end

  // R8: accept and reject are never flagged together
  assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ok_o, bad_o}));

  // R1: collection index never runs past the descriptor length
  assert_index_bound_R1: assert property (@(posedge clk) disable iff (rst)
    idx <= IW'(DESC_BYTES));

  // R8: a handed-over timing is always reported as accepted
  assert_new_is_ok_R8: assert property (@(posedge clk) disable iff (rst)
    cfg_new_o |-> ok_o);

endmodule

// File: rtl/vtg_axis_cnt.sv
module vtg_axis_cnt #(
  parameter int W = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       step,
  input  logic [W:0] total,
  output logic [W:0] cnt_o,
  output logic       wrap_o
);

  logic [W:0] nxt;

  assign nxt    = cnt_o + 1'b1;
  assign wrap_o = step && (nxt == total);

  always_ff @(posedge clk) begin
    if (rst)       cnt_o <= '0;
    else if (clr)  cnt_o <= '0;
    else if (step) cnt_o <= wrap_o ? '0 : nxt;
  end

  // R3 and R4: a stepping counter stays inside its total
  assert_cnt_below_total_R3: assert property (@(posedge clk) disable iff (rst)
    step |-> (cnt_o < total));

  // R3 and R4: each step either advances by one or returns to zero
  assert_cnt_advance_R3: assert property (@(posedge clk) disable iff (rst)
    (step && !clr) |=> ((cnt_o == $past(cnt_o) + 1'b1) || (cnt_o == '0)));

endmodule

// File: rtl/vtg_axis_phase.sv
module vtg_axis_phase
  import vtg_pkg::*;
#(
  parameter int W = AXW
) (
  input  logic [W:0] cnt,
  input  axis_cfg_t  cfg,
  output logic       in_act,
  output logic       sync_lvl
);

  localparam int TW = W + 2;

  logic [TW-1:0] s_begin;
  logic [TW-1:0] s_end;
  logic [TW-1:0] c_ext;
  logic          in_sync;

  assign c_ext   = TW'(cnt);
  assign s_begin = TW'(cfg.act) + TW'(cfg.fp);
  assign s_end   = s_begin + TW'(cfg.sw);
  assign in_act  = c_ext < TW'(cfg.act);
  assign in_sync = (c_ext >= s_begin) && (c_ext < s_end);
  assign sync_lvl = in_sync ? cfg.pol : !cfg.pol;

endmodule

// File: rtl/vtg_desc_top.sv
module vtg_desc_top
  import vtg_pkg::*;
#(
  parameter int CW = AXW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_valid,
  input  logic             ld_sof,
  input  logic [7:0]       ld_data,
  output logic             desc_ok,
  output logic             desc_bad,
  output logic             timing_run,
  output logic [CW:0]      h_pos,
  output logic [CW:0]      v_pos,
  output logic [CW-1:0]    act_x,
  output logic [CW-1:0]    act_y,
  output logic             de,
  output logic             hsync,
  output logic             vsync,
  output logic [RATEW-1:0] pix_rate_khz,
  output logic [3:0]       aspect_code,
  output logic             interlaced,
  output logic [1:0]       stereo_mode,
  output logic             preferred
);

  tim_cfg_t    new_cfg;
  logic        new_v;
  tim_cfg_t    pend_q;
  logic        pend_v;
  tim_cfg_t    cfg_q;
  logic        running;
  logic        apply;
  logic [CW:0] h_cnt;
  logic [CW:0] v_cnt;
  logic        h_wrap;
  logic        v_wrap;
  logic [CW:0] h_tot;
  logic [CW:0] v_tot;
  logic        h_in, v_in, h_lvl, v_lvl;

  vtg_desc_loader u_loader (
    .clk       (clk),
    .rst       (rst),
    .ld_valid  (ld_valid),
    .ld_sof    (ld_sof),
    .ld_data   (ld_data),
    .cfg_o     (new_cfg),
    .cfg_new_o (new_v),
    .ok_o      (desc_ok),
    .bad_o     (desc_bad)
  );

  // pending slot: a fresh descriptor overrides one still waiting
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      pend_v <= 1'b0;
    end else begin
      if (apply) pend_v <= 1'b0;
      if (new_v) begin
        pend_q <= new_cfg;
        pend_v <= 1'b1;
      end
    end
  end

  assign apply = pend_v && (!running || v_wrap);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q   <= '0;
      running <= 1'b0;
    end else if (apply) begin
      cfg_q   <= pend_q;
      running <= 1'b1;
    end
  end

  assign h_tot = (CW+1)'(cfg_q.h.act) + (CW+1)'(cfg_q.h.blank);
  assign v_tot = (CW+1)'(cfg_q.v.act) + (CW+1)'(cfg_q.v.blank);

  vtg_axis_cnt #(.W(CW)) u_hcnt (
    .clk    (clk),
    .rst    (rst),
    .clr    (apply),
    .step   (running),
    .total  (h_tot),
    .cnt_o  (h_cnt),
    .wrap_o (h_wrap)
  );

  vtg_axis_cnt #(.W(CW)) u_vcnt (
    .clk    (clk),
    .rst    (rst),
    .clr    (apply),
    .step   (running && h_wrap),
    .total  (v_tot),
    .cnt_o  (v_cnt),
    .wrap_o (v_wrap)
  );

  vtg_axis_phase #(.W(CW)) u_hphase (
    .cnt      (h_cnt),
    .cfg      (cfg_q.h),
    .in_act   (h_in),
    .sync_lvl (h_lvl)
  );

  vtg_axis_phase #(.W(CW)) u_vphase (
    .cnt      (v_cnt),
    .cfg      (cfg_q.v),
    .in_act   (v_in),
    .sync_lvl (v_lvl)
  );

  // single aligned output stage
  always_ff @(posedge clk) begin
    if (rst) begin
      timing_run <= 1'b0;
      h_pos      <= '0;
      v_pos      <= '0;
      act_x      <= '0;
      act_y      <= '0;
      de         <= 1'b0;
      hsync      <= 1'b0;
      vsync      <= 1'b0;
    end else begin
      timing_run <= running;
      h_pos      <= h_cnt;
      v_pos      <= v_cnt;
      de         <= running && h_in && v_in;
      act_x      <= (running && h_in && v_in) ? h_cnt[CW-1:0] : '0;
      act_y      <= (running && h_in && v_in) ? v_cnt[CW-1:0] : '0;
      hsync      <= running && h_lvl;
      vsync      <= running && v_lvl;
    end
  end

  assign pix_rate_khz = cfg_q.rate;
  assign aspect_code  = cfg_q.aspect;
  assign interlaced   = cfg_q.ilace;
  assign stereo_mode  = cfg_q.stereo;
  assign preferred    = cfg_q.pref;

  // R7: live timing only changes when both counters restart a frame
  assert_swap_at_frame_R7: assert property (@(posedge clk) disable iff (rst)
    (cfg_q != $past(cfg_q)) |-> ((h_cnt == '0) && (v_cnt == '0)));

  // R4: line count moves only on a horizontal restart
  assert_vstep_on_hwrap_R4: assert property (@(posedge clk) disable iff (rst)
    (running && $past(running) && (v_cnt != $past(v_cnt))) |-> (h_cnt == '0));

  // R5 and R9: no data enable without a running raster
  assert_de_needs_run_R5: assert property (@(posedge clk) disable iff (rst)
    de |-> timing_run);

endmodule

// File: tb/vtg_desc_top_tb_top.sv
module vtg_desc_top_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_valid = 1'b0;
  logic        ld_sof = 1'b0;
  logic [7:0]  ld_data = 8'h00;
  logic        desc_ok, desc_bad, timing_run, de, hsync, vsync;
  logic [16:0] h_pos, v_pos;
  logic [15:0] act_x, act_y;
  logic [23:0] pix_rate_khz;
  logic [3:0]  aspect_code;
  logic        interlaced, preferred;
  logic [1:0]  stereo_mode;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  vtg_desc_top dut_i (
    .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_sof(ld_sof), .ld_data(ld_data),
    .desc_ok(desc_ok), .desc_bad(desc_bad), .timing_run(timing_run),
    .h_pos(h_pos), .v_pos(v_pos), .act_x(act_x), .act_y(act_y), .de(de),
    .hsync(hsync), .vsync(vsync), .pix_rate_khz(pix_rate_khz), .aspect_code(aspect_code),
    .interlaced(interlaced), .stereo_mode(stereo_mode), .preferred(preferred)
  );

  function automatic logic [160:0] mk(input logic ok, input logic [23:0] rate, input logic [7:0] opt,
      input logic [15:0] ha, input logic [15:0] hb, input logic [14:0] hfp, input logic hp,
      input logic [15:0] hsw, input logic [15:0] va, input logic [15:0] vb,
      input logic [14:0] vfp, input logic vp, input logic [15:0] vsw);
    return {ok, vsw, vp, vfp, vb, va, hsw, hp, hfp, hb, ha, opt, rate};
  endfunction

  localparam int NV = 5;
  localparam logic [160:0] VEC [NV] = '{
    mk(1'b1, 24'h01A2B3, 8'h94, 16'd16, 16'd8, 15'd2, 1'b1, 16'd3, 16'd6, 16'd4, 15'd1, 1'b0, 16'd2),
    mk(1'b0, 24'h111111, 8'h00, 16'd20, 16'd6, 15'd4, 1'b1, 16'd3, 16'd6, 16'd4, 15'd1, 1'b0, 16'd2),
    mk(1'b1, 24'h00FFFF, 8'h25, 16'd12, 16'd6, 15'd0, 1'b0, 16'd6, 16'd8, 16'd3, 15'd3, 1'b1, 16'd0),
    mk(1'b0, 24'h222222, 8'h00, 16'd16, 16'd8, 15'd2, 1'b1, 16'd3, 16'd0, 16'd4, 15'd1, 1'b0, 16'd2),
    mk(1'b1, 24'hFEDCBA, 8'h48, 16'd20, 16'd10, 15'd5, 1'b0, 16'd1, 16'd5, 16'd2, 15'd0, 1'b1, 16'd2)
  };

  logic [159:0] cur_vec = '0;
  logic [159:0] pend_vec = '0;
  logic         pend_v = 1'b0;
  logic [159:0] live_vec = '0;
  logic         prev_run = 1'b0;
  logic [16:0]  prev_h = '0, prev_v = '0;

  task automatic chk(input logic cond, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // raster monitor: successor, enable, coordinates, sync levels
  always @(negedge clk) begin
    if (!rst && timing_run) begin
      logic [16:0] ht, vt, eh, ev, hs0, vs0;
      logic        ed, ehs, evs;
      ht = 17'(cur_vec[47:32]) + 17'(cur_vec[63:48]);
      vt = 17'(cur_vec[111:96]) + 17'(cur_vec[127:112]);
      if (!prev_run) begin
        eh = 0; ev = 0;
        cur_vec = pend_vec; pend_v = 1'b0;
        chk(h_pos == 0 && v_pos == 0, "R7", "first frame start", {h_pos, v_pos}, 0);
      end else begin
        if (prev_h == ht - 1 && prev_v == vt - 1) begin
          eh = 0; ev = 0;
          if (pend_v) begin cur_vec = pend_vec; pend_v = 1'b0; end
          chk(h_pos == 0 && v_pos == 0, "R7", "frame boundary", {h_pos, v_pos}, 0);
        end else if (prev_h == ht - 1) begin
          eh = 0; ev = prev_v + 1;
          chk(h_pos == eh && v_pos == ev, "R4", "line advance", {h_pos, v_pos}, {eh, ev});
        end else begin
          eh = prev_h + 1; ev = prev_v;
          chk(h_pos == eh && v_pos == ev, "R3", "pixel advance", {h_pos, v_pos}, {eh, ev});
        end
      end
      ed = (h_pos < 17'(cur_vec[47:32])) && (v_pos < 17'(cur_vec[111:96]));
      chk(de == ed && act_x == (ed ? h_pos[15:0] : 16'd0) && act_y == (ed ? v_pos[15:0] : 16'd0),
          "R5", "enable/coords", {de, act_x, act_y}, {ed, (ed ? h_pos[15:0] : 16'd0), (ed ? v_pos[15:0] : 16'd0)});
      hs0 = 17'(cur_vec[47:32]) + 17'(cur_vec[78:64]);
      vs0 = 17'(cur_vec[111:96]) + 17'(cur_vec[142:128]);
      ehs = (h_pos >= hs0 && h_pos < hs0 + 17'(cur_vec[95:80])) ? cur_vec[79] : !cur_vec[79];
      evs = (v_pos >= vs0 && v_pos < vs0 + 17'(cur_vec[159:144])) ? cur_vec[143] : !cur_vec[143];
      chk(hsync == ehs && vsync == evs, "R6", "sync levels", {hsync, vsync}, {ehs, evs});
    end
    prev_run = timing_run;
    prev_h = h_pos;
    prev_v = v_pos;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic send(input logic [159:0] d, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ld_valid = 1'b1;
      ld_sof   = (i == 0);
      ld_data  = (i < 20) ? d[8*i +: 8] : 8'hFF;
    end
    @(negedge clk);
    ld_valid = 1'b0;
    ld_sof   = 1'b0;
  endtask

  task automatic wait_sync();
    if (timing_run) begin
      do @(negedge clk); while (!(h_pos == 0 && v_pos == 1));
    end
  endtask

  task automatic check_fields(input logic [159:0] v, input string req);
    chk(pix_rate_khz == v[23:0] && aspect_code == v[27:24] && interlaced == v[28] &&
        stereo_mode == v[30:29] && preferred == v[31], req, "live fields",
        {pix_rate_khz, aspect_code, interlaced, stereo_mode, preferred}, {v[23:0], v[27:24], v[28], v[30:29], v[31]});
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: quiet outputs after reset
    chk(!de && !hsync && !vsync && !timing_run && h_pos == 0 && v_pos == 0 && !desc_ok && !desc_bad,
        "R9", "reset state", {de, hsync, vsync, timing_run, h_pos, v_pos}, 0);
    repeat (10) @(negedge clk);
    chk(!timing_run && h_pos == 0 && pix_rate_khz == 0, "R9", "idle before load", {timing_run, h_pos}, 0);

    // table walk: accepted and rejected descriptors
    for (int i = 0; i < NV; i++) begin
      logic [159:0] d;
      logic         ok;
      d  = VEC[i][159:0];
      ok = VEC[i][160];
      wait_sync();
      send(d, 20);
      if (ok) begin pend_vec = d; pend_v = 1'b1; live_vec = d; end
      repeat (4) @(negedge clk);
      chk(desc_ok == ok && desc_bad == !ok, "R8", "status flags", {desc_ok, desc_bad}, {ok, !ok});
      repeat (900) @(negedge clk);
      check_fields(live_vec, ok ? "R2" : "R8");
      chk(pend_v == 1'b0, "R7", "pending applied", pend_v, 0);
    end

    // R1: truncated load then restart with trailing extra bytes
    wait_sync();
    send(160'hDEADBEEF_0000_0000_0000_0000_0000_0000, 5);
    repeat (3) @(negedge clk);
    chk(!desc_ok && !desc_bad, "R1", "partial load flags", {desc_ok, desc_bad}, 0);
    send(VEC[0][159:0], 23);
    pend_vec = VEC[0][159:0]; pend_v = 1'b1; live_vec = VEC[0][159:0];
    repeat (4) @(negedge clk);
    chk(desc_ok && !desc_bad, "R1", "restart accepted", {desc_ok, desc_bad}, 2'b10);
    repeat (900) @(negedge clk);
    check_fields(live_vec, "R1");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule